// File: doc/BRIEF.md
# Priority Chip-Select Configuration Controller

This block sets up and decodes the chip selects of a 20-bit address space that is shared by five memory modules, ranked by a fixed priority. Each module is placed by a two-step chain of commands. Its first CONFIG supplies an address mask and its second supplies the base, and every CONFIG goes to the highest-ranked module that is not yet placed. UNCONFIG removes the highest-ranked placed module whose base matches the given address. RESET brings the whole chain back to its start. An ID code tells software which module the chain is waiting for.

Module 0 is the I/O window. Its size is fixed, so its mask is preset on reset and only its base has to be set. When module 0 is unconfigured it falls back to the mask-known state, not to unconfigured. Modules 1 to 4 are RAM, bank-select, port 1 and port 2.

For every bus address the block drives a one-hot select vector. The lowest-indexed placed module whose window covers the address wins that address. A mask that is not a contiguous run of ones above a run of zeros never decodes. An external mode input suppresses the select of the port-2 module (index 4).

Top module: `chipsel_cfg`

## Requirements
- R1: After the reset pin or a RESET command, module 0 is mask-known with mask 0xFFFC0, modules 1 to 4 are unconfigured, id_code reads 0x9 and no select is driven.
- R2: A CONFIG whose target module is unconfigured stores cmd_data as that module's mask and makes the module mask-known.
- R3: A CONFIG whose target module is mask-known stores cmd_data AND mask as its base and makes the module configured.
- R4: The target of CONFIG is the lowest-indexed module that is not configured. When all five are configured, CONFIG has no effect.
- R5: UNCONFIG acts on the lowest-indexed configured module whose base equals cmd_data AND its mask. Module 0 returns to mask-known and any other module returns to unconfigured. At most one module changes per command, and an address that matches no module changes nothing.
- R6: id_code is 0 when every module is configured. Otherwise bits [2:0] hold the index plus one of the lowest-indexed pending module, and bit 3 is 1 when that module is mask-known. id_code is combinational from the module states.
- R7: sel[i] is set for module i when it is configured and (bus_addr AND mask) equals its base. Where windows overlap, the lowest index wins, so at most one select bit is set.
- R8: A configured module whose mask is not a run of ones followed by a run of zeros never asserts its select.
- R9: While hi_addr_mode is 1, sel[4] stays 0. The other selects are unaffected.
- R10: Strobes in the same cycle follow a priority. RESET wins over CONFIG and CONFIG wins over UNCONFIG. Commands take effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_reset | input | 1 | One-cycle RESET command strobe |
| cmd_config | input | 1 | One-cycle CONFIG command strobe |
| cmd_unconfig | input | 1 | One-cycle UNCONFIG command strobe |
| cmd_data | input | 20 | CONFIG data word or UNCONFIG address |
| id_code | output | 4 | Pending-module identifier (R6 encoding) |
| bus_addr | input | 20 | Address to decode |
| hi_addr_mode | input | 1 | Suppresses the port-2 select when high |
| sel | output | 5 | One-hot module select, bit i for module i |

## Verification
The situations hardest to reach are the overlapping window and the malformed mask. They only exist after the chain has walked through every module before them in the right order, because a command can never address a module directly. The stimulus table therefore drives complete chains of CONFIG and UNCONFIG commands and checks the ID code after each step. The select checks then run against the layout that the chain has built. This layout places the bank-select window inside the port-1 window, and a later chain gives the RAM module a broken mask.

// File: rtl/cscfg_pkg.sv
package cscfg_pkg;

  typedef enum logic [1:0] {
    ST_UNCFG = 2'd0,
    ST_MASKK = 2'd1,
    ST_CFGD  = 2'd2
  } slot_state_e;

  // True when the low w bits of m are ones above zeros (zeros may be empty).
  function automatic logic mask_ok(input logic [63:0] m, input int w);
    logic [63:0] lim;
    logic [63:0] inv;
    lim = (64'd1 << w) - 64'd1;
    inv = ~m & lim;
    return (inv & (inv + 64'd1)) == 64'd0;
  endfunction

  // Window hit for one slot, independent of priority.
  function automatic logic window_hit(input logic [63:0] addr, input logic [63:0] mask,
                                      input logic [63:0] base);
    return (addr & mask) == base;
  endfunction

endpackage

// File: rtl/cscfg_slot.sv
module cscfg_slot
  import cscfg_pkg::*;
#(
  parameter int          ADDR_W     = 20,
  parameter bit          IS_FIXED   = 1'b0,
  parameter logic [ADDR_W-1:0] FIXED_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_reset,
  input  logic              do_cfg,
  input  logic              do_uncfg,
  input  logic [ADDR_W-1:0] data,
  output slot_state_e       state,
  output logic [ADDR_W-1:0] mask,
  output logic [ADDR_W-1:0] base
);

  localparam slot_state_e HOME_ST   = IS_FIXED ? ST_MASKK : ST_UNCFG;
  localparam logic [ADDR_W-1:0] HOME_MASK = IS_FIXED ? FIXED_MASK : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HOME_ST;
      mask  <= HOME_MASK;
      base  <= '0;
    end else if (do_reset) begin
      state <= HOME_ST;
      mask  <= HOME_MASK;
      base  <= '0;
    end else if (do_cfg) begin
      case (state)
        ST_UNCFG: begin
          mask  <= data;
          state <= ST_MASKK;
        end
        ST_MASKK: begin
          base  <= data & mask;
          state <= ST_CFGD;
        end
        default: ;
      endcase
    end else if (do_uncfg) begin
      state <= HOME_ST;
    end
  end

  // R1: reset command returns the slot to its home state
  p_home_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    do_reset |=> (state == HOME_ST && mask == HOME_MASK));

  // R2: first chain step records the mask
  p_mask_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (do_cfg && !do_reset && state == ST_UNCFG) |=> (state == ST_MASKK && mask == $past(data)));

  // R3: second chain step records the masked base
  p_base_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_cfg && !do_reset && state == ST_MASKK)
      |=> (state == ST_CFGD && base == ($past(data) & $past(mask))));

  // R5: removal lands on the home state
  p_remove_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_uncfg && !do_cfg && !do_reset) |=> (state == HOME_ST));

endmodule

// File: rtl/cscfg_arbiter.sv
module cscfg_arbiter
  import cscfg_pkg::*;
#(
  parameter int NUM_MOD = 5,
  parameter int ADDR_W  = 20,
  parameter int ID_W    = $clog2(NUM_MOD + 1) + 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  slot_state_e [NUM_MOD-1:0]      states,
  input  logic [NUM_MOD-1:0][ADDR_W-1:0] masks,
  input  logic [NUM_MOD-1:0][ADDR_W-1:0] bases,
  input  logic                           cmd_reset,
  input  logic                           cmd_config,
  input  logic                           cmd_unconfig,
  input  logic [ADDR_W-1:0]              cmd_data,
  output logic [NUM_MOD-1:0]             cfg_evt,
  output logic [NUM_MOD-1:0]             unc_evt,
  output logic [ID_W-1:0]                id_code
);

  localparam int IDX_W = ID_W - 1;

  logic [NUM_MOD-1:0] pend_oh;
  logic [NUM_MOD-1:0] unc_oh;
  logic               pend_found;
  logic               unc_found;

  always_comb begin
    pend_oh    = '0;
    unc_oh     = '0;
    id_code    = '0;
    pend_found = 1'b0;
    unc_found  = 1'b0;
    for (int i = 0; i < NUM_MOD; i++) begin
      if (!pend_found && states[i] != ST_CFGD) begin
        pend_found = 1'b1;
        pend_oh[i] = 1'b1;
        id_code    = {states[i] == ST_MASKK, IDX_W'(i + 1)};
      end
      if (!unc_found && states[i] == ST_CFGD && bases[i] == (cmd_data & masks[i])) begin
        unc_found = 1'b1;
        unc_oh[i] = 1'b1;
      end
    end
  end

  assign cfg_evt = (cmd_config && !cmd_reset) ? pend_oh : '0;
  assign unc_evt = (cmd_unconfig && !cmd_config && !cmd_reset) ? unc_oh : '0;

  // R4: a config strobe with nothing pending reaches no slot
  p_cfg_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (id_code == '0) |-> (cfg_evt == '0));

  // R10: unconfig never acts in the same cycle as another strobe
  p_strobe_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_reset || cmd_config) |-> (unc_evt == '0));

  // R5: at most one slot is addressed by a removal
  p_single_remove_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unc_evt));

endmodule

// File: rtl/cscfg_match.sv
module cscfg_match
  import cscfg_pkg::*;
#(
  parameter int NUM_MOD   = 5,
  parameter int ADDR_W    = 20,
  parameter int GATED_IDX = NUM_MOD - 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              addr,
  input  slot_state_e [NUM_MOD-1:0]      states,
  input  logic [NUM_MOD-1:0][ADDR_W-1:0] masks,
  input  logic [NUM_MOD-1:0][ADDR_W-1:0] bases,
  input  logic                           gate_off,
  output logic [NUM_MOD-1:0]             sel
);

  logic [NUM_MOD-1:0] hit;
  logic [NUM_MOD-1:0] shape_ok;

  for (genvar g = 0; g < NUM_MOD; g++) begin : g_hit
    logic gated;
    assign gated       = (g == GATED_IDX) ? gate_off : 1'b0;
    assign shape_ok[g] = mask_ok(64'(masks[g]), ADDR_W);
    assign hit[g]      = (states[g] == ST_CFGD) && shape_ok[g] && !gated &&
                         window_hit(64'(addr), 64'(masks[g]), 64'(bases[g]));

    // R8: a malformed mask never produces a select
    p_bad_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_ok(64'(masks[g]), ADDR_W) |-> !sel[g]);

    // R7: a select implies a configured slot whose window covers the address
    p_sel_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sel[g] |-> (states[g] == ST_CFGD && (addr & masks[g]) == bases[g]));
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_MOD; i++) begin
      if (hit[i] && sel == '0) sel[i] = 1'b1;
    end
  end

  // R7: one winner at most
  p_onehot_sel_r7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel));

  // R9: the gated slot stays silent under the disable input
  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gate_off |-> !sel[GATED_IDX]);

endmodule

// File: rtl/chipsel_cfg.sv
module chipsel_cfg
  import cscfg_pkg::*;
#(
  parameter int                NUM_MOD  = 5,
  parameter int                ADDR_W   = 20,
  parameter logic [ADDR_W-1:0] IO_MASK  = 20'hFFFC0,
  parameter int                ID_W     = $clog2(NUM_MOD + 1) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_reset,
  input  logic               cmd_config,
  input  logic               cmd_unconfig,
  input  logic [ADDR_W-1:0]  cmd_data,
  output logic [ID_W-1:0]    id_code,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               hi_addr_mode,
  output logic [NUM_MOD-1:0] sel
);

  slot_state_e [NUM_MOD-1:0]      st;
  logic [NUM_MOD-1:0][ADDR_W-1:0] msk;
  logic [NUM_MOD-1:0][ADDR_W-1:0] bse;
  logic [NUM_MOD-1:0]             cfg_evt;
  logic [NUM_MOD-1:0]             unc_evt;

  for (genvar g = 0; g < NUM_MOD; g++) begin : g_slot
    cscfg_slot #(
      .ADDR_W    (ADDR_W),
      .IS_FIXED  (g == 0),
      .FIXED_MASK(IO_MASK)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .do_reset(cmd_reset),
      .do_cfg  (cfg_evt[g]),
      .do_uncfg(unc_evt[g]),
      .data    (cmd_data),
      .state   (st[g]),
      .mask    (msk[g]),
      .base    (bse[g])
    );
  end

  cscfg_arbiter #(
    .NUM_MOD(NUM_MOD),
    .ADDR_W (ADDR_W),
    .ID_W   (ID_W)
  ) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .states      (st),
    .masks       (msk),
    .bases       (bse),
    .cmd_reset   (cmd_reset),
    .cmd_config  (cmd_config),
    .cmd_unconfig(cmd_unconfig),
    .cmd_data    (cmd_data),
    .cfg_evt     (cfg_evt),
    .unc_evt     (unc_evt),
    .id_code     (id_code)
  );

  cscfg_match #(
    .NUM_MOD  (NUM_MOD),
    .ADDR_W   (ADDR_W),
    .GATED_IDX(NUM_MOD - 1)
  ) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (bus_addr),
    .states  (st),
    .masks   (msk),
    .bases   (bse),
    .gate_off(hi_addr_mode),
    .sel     (sel)
  );

  // Previous-cycle states, kept only to observe how many slots move.
  slot_state_e [NUM_MOD-1:0] st_q;
  logic [NUM_MOD-1:0]        moved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= st;
    else        st_q <= st;
  end

  always_comb begin
    for (int i = 0; i < NUM_MOD; i++) moved[i] = (st[i] != st_q[i]);
  end

  // R5: outside of a reset, a command moves one slot at most
  p_one_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_reset) |-> ($countones(moved) <= 1));

  // R4: with nothing pending, config leaves every mask in place
  p_cfg_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_config && !cmd_reset && id_code == '0) |=> $stable(msk) && $stable(bse));

endmodule

// File: tb/tb_chipsel_cfg.sv
`timescale 1ns/1ps
module tb_chipsel_cfg;

  localparam int OP_RST = 0;
  localparam int OP_CFG = 1;
  localparam int OP_UNC = 2;

  typedef struct packed {
    logic [1:0]  op;
    logic [19:0] data;
    logic [3:0]  exp_id;
    logic [7:0]  req;
  } step_t;

  localparam int NSTEP = 26;
  localparam step_t STEPS [0:NSTEP-1] = '{
    '{2'd1, 20'h00100, 4'h2, 8'd3},   // R3 module 0 base
    '{2'd1, 20'hC0000, 4'hA, 8'd2},   // R2 module 1 mask
    '{2'd1, 20'h80000, 4'h3, 8'd3},
    '{2'd1, 20'hFF800, 4'hB, 8'd2},
    '{2'd1, 20'h70000, 4'h4, 8'd3},
    '{2'd1, 20'hC0000, 4'hC, 8'd2},
    '{2'd1, 20'h40000, 4'h5, 8'd3},
    '{2'd1, 20'hC0000, 4'hD, 8'd2},
    '{2'd1, 20'hC0000, 4'h0, 8'd6},   // R6 all configured
    '{2'd1, 20'h12345, 4'h0, 8'd4},   // R4 ignored
    '{2'd2, 20'h00000, 4'h0, 8'd5},   // R5 no match
    '{2'd2, 20'h80123, 4'h2, 8'd5},   // R5 module 1 removed
    '{2'd1, 20'hC0000, 4'hA, 8'd4},   // R4 chain resumes at module 1
    '{2'd1, 20'h80000, 4'h0, 8'd3},
    '{2'd2, 20'h00123, 4'h9, 8'd5},   // R5 module 0 back to mask-known
    '{2'd1, 20'h00200, 4'h0, 8'd3},
    '{2'd0, 20'h00000, 4'h9, 8'd1},   // R1 reset command
    '{2'd1, 20'h00100, 4'h2, 8'd3},
    '{2'd1, 20'hC0000, 4'hA, 8'd2},
    '{2'd1, 20'h80000, 4'h3, 8'd3},
    '{2'd1, 20'hFF800, 4'hB, 8'd2},
    '{2'd1, 20'h70000, 4'h4, 8'd3},
    '{2'd1, 20'hC0000, 4'hC, 8'd2},
    '{2'd1, 20'h40000, 4'h5, 8'd3},
    '{2'd1, 20'hC0000, 4'hD, 8'd2},
    '{2'd1, 20'hC0000, 4'h0, 8'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_reset = 1'b0;
  logic        cmd_config = 1'b0;
  logic        cmd_unconfig = 1'b0;
  logic [19:0] cmd_data = '0;
  logic [3:0]  id_code;
  logic [19:0] bus_addr = '0;
  logic        hi_addr_mode = 1'b0;
  logic [4:0]  sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chipsel_cfg dut (
    .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .cmd_config(cmd_config),
    .cmd_unconfig(cmd_unconfig), .cmd_data(cmd_data), .id_code(id_code),
    .bus_addr(bus_addr), .hi_addr_mode(hi_addr_mode), .sel(sel)
  );

  task automatic check_val(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input bit r, input bit c, input bit u, input logic [19:0] d);
    @(negedge clk);
    cmd_reset = r; cmd_config = c; cmd_unconfig = u; cmd_data = d;
    @(negedge clk);
    cmd_reset = 1'b0; cmd_config = 1'b0; cmd_unconfig = 1'b0;
  endtask

  task automatic probe(input string req, input logic [19:0] a, input bit hm, input logic [4:0] exp);
    @(negedge clk);
    bus_addr = a; hi_addr_mode = hm;
    #1;
    check_val(req, 20'(sel), 20'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset pin state
    check_val("R1 id after pin reset", 20'(id_code), 20'h9);
    bus_addr = 20'h00000;
    #1;
    check_val("R1 no select after reset", 20'(sel), 20'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: commands with the expected ID after each one
    for (int k = 0; k < NSTEP; k++) begin
      strobe(STEPS[k].op == 2'(OP_RST), STEPS[k].op == 2'(OP_CFG),
             STEPS[k].op == 2'(OP_UNC), STEPS[k].data);
      checks++;
      if (id_code !== STEPS[k].exp_id) begin
        errors++;
        $display("FAIL R%0d step %0d actual=%h expected=%h", STEPS[k].req, k, id_code,
                 STEPS[k].exp_id);
      end
    end

    // R7 decode of the built layout
    probe("R7 io window",        20'h00105, 1'b0, 5'b00001);
    probe("R7 ram window",       20'h80000, 1'b0, 5'b00010);
    probe("R7 overlap priority", 20'h70010, 1'b0, 5'b00100);
    probe("R7 port1 window",     20'h50000, 1'b0, 5'b01000);
    probe("R7 port2 window",     20'hC1234, 1'b0, 5'b10000);
    probe("R7 unmapped",         20'h20000, 1'b0, 5'b00000);
    // R9 disable of the port-2 select only
    probe("R9 port2 suppressed", 20'hC1234, 1'b1, 5'b00000);
    probe("R9 port1 unaffected", 20'h50000, 1'b1, 5'b01000);
    hi_addr_mode = 1'b0;

    // R10 reset beats config in the same cycle
    strobe(1'b1, 1'b1, 1'b0, 20'h00000);
    check_val("R10 reset over config", 20'(id_code), 20'h9);
    // R10 config beats unconfig in the same cycle
    strobe(1'b0, 1'b1, 1'b1, 20'h00000);
    check_val("R10 config over unconfig", 20'(id_code), 20'h2);

    // R8 broken mask on module 1
    strobe(1'b0, 1'b1, 1'b0, 20'hF0F00);
    check_val("R2 broken mask stored", 20'(id_code), 20'hA);
    strobe(1'b0, 1'b1, 1'b0, 20'h10000);
    check_val("R3 broken mask module configured", 20'(id_code), 20'h3);
    probe("R8 broken mask no select", 20'h10000, 1'b0, 5'b00000);
    strobe(1'b0, 1'b0, 1'b1, 20'h10000);
    check_val("R5 remove module 1", 20'(id_code), 20'h2);
    strobe(1'b0, 1'b1, 1'b0, 20'hF0000);
    strobe(1'b0, 1'b1, 1'b0, 20'h10000);
    check_val("R3 good mask configured", 20'(id_code), 20'h3);
    probe("R8 good mask decodes", 20'h10000, 1'b0, 5'b00010);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule